// File: doc/BRIEF.md
# Dual-Counter Interval Timer

This block is a register-mapped timer built from two independent counters that share one control word. The first is a reloadable down-counter. Its tick comes from a programmable pre-divider followed by a fixed prescale stage of 1, 16 or 256. When the count is at zero on a tick, the counter reloads from a stored reload value and raises a pending interrupt flag. The flag reaches the interrupt pin only when the interrupt-enable bit is set. The second counter is a free-running up-counter with its own 8-bit divisor. Software can read it as a time base.

Software drives the block through a simple word-addressed bus with a single-cycle write strobe and a combinational read path. A debug-halt input can freeze both counters when the control word allows it. After reset everything is zero, so both counters start out stopped.

Top module: `dct_timer`

## Requirements
- R1: After reset every readable register is zero and irq_o is low.
- R2: Word index 0 is load, 1 current value, 2 control, 3 interrupt clear, 4 raw flag (bit 0), 5 masked flag (bit 0), 6 reload, 7 pre-divider, 8 free count. Writes to indexes 1, 4, 5 and 8 are ignored. Index 3 and unused indexes read zero. Control bits other than 1, [3:2], 5, 7, 8, 9 and [23:16] read zero.
- R3: A write to index 0 stores the data as the reload value and as the current value in the same edge. It also restarts the prescale chain, and it takes priority over a tick in that cycle. A write to index 6 changes only the reload value. Both indexes read back the reload value.
- R4: With control bit 7 set, each tick decrements the value. A tick that finds the value at zero reloads it and sets the raw flag, so an event occurs every reload+1 ticks.
- R5: Ticks come at clk/((P+1)*N), where P is the pre-divider and N is picked by control [3:2]: 0 gives 1, 1 gives 16, 2 gives 256 and 3 gives 1.
- R6: Control bit 1 picks the width: 1 gives 32 bits, 0 gives 16 bits. In 16-bit mode the zero test uses bits [15:0] only, and the value reads with its upper half zero.
- R7: A write of any data to index 3 clears the raw flag. If an underflow happens in the same cycle, the flag stays set.
- R8: The masked flag and irq_o are the raw flag ANDed with control bit 5.
- R9: With control bit 9 set, the free count increments once every D+1 cycles, where D is control [23:16]. With bit 9 clear it holds.
- R10: While control bit 8 and dbg_halt_i are both high, both counters and their prescalers hold. With bit 8 clear, dbg_halt_i has no effect.
- R11: With control bit 7 clear, the value holds and the prescale chain restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| dbg_halt_i | input | 1 | Debug halt request |
| irq_o | output | 1 | Interrupt, raw flag masked by enable |

## Verification
A write to the interrupt-clear index and a down-counter underflow can land on the same edge, and R7 requires the new event to win. The bench provokes this by loading zero with the counter running at full rate, so every edge underflows. It then issues the clear and confirms that the raw flag is still set. After stopping the counter, a second clear must empty the flag. A load write landing on a tick edge is handled the same way: the loaded value must appear unchanged, and the decrement must start one edge later.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [3:0] {
    IDX_LOAD   = 4'd0,
    IDX_VALUE  = 4'd1,
    IDX_CTRL   = 4'd2,
    IDX_CLEAR  = 4'd3,
    IDX_RAW    = 4'd4,
    IDX_MASKED = 4'd5,
    IDX_RELOAD = 4'd6,
    IDX_PREDIV = 4'd7,
    IDX_FREE   = 4'd8
  } dct_idx_e;

  localparam int CB_WIDE    = 1;
  localparam int CB_PRE_LO  = 2;
  localparam int CB_IE      = 5;
  localparam int CB_RUN     = 7;
  localparam int CB_HALT_EN = 8;
  localparam int CB_FREE_EN = 9;
  localparam int CB_FDIV_LO = 16;

  localparam logic [31:0] CTRL_WMASK = 32'h00FF_03AE;

  localparam int PRESCALE_W = 8;

  function automatic logic [PRESCALE_W-1:0] prescale_limit(input logic [1:0] sel);
    case (sel)
      2'd1:    prescale_limit = PRESCALE_W'(15);
      2'd2:    prescale_limit = PRESCALE_W'(255);
      default: prescale_limit = '0;
    endcase
  endfunction

endpackage

// File: rtl/dct_rst_sync.sv
module dct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/dct_divider.sv
module dct_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dct_down_counter.sv
module dct_down_counter
  import dct_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PREDIV_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                halt,
  input  logic                wide,
  input  logic [1:0]          pre_sel,
  input  logic [PREDIV_W-1:0] prediv,
  input  logic                load_wr,
  input  logic [DATA_W-1:0]   load_data,
  input  logic [DATA_W-1:0]   reload,
  output logic [DATA_W-1:0]   value_q,
  output logic [DATA_W-1:0]   value_rd,
  output logic                underflow
);
  localparam int HALF_W = DATA_W / 2;

  logic base_tick, cnt_tick, chain_clr, zero;
  logic [DATA_W-1:0] value_d;

  assign chain_clr = !run || load_wr;

  dct_divider #(.W(PREDIV_W)) i_base (
    .clk(clk), .rst_n(rst_n), .en(run && !halt), .clr(chain_clr),
    .limit(prediv), .tick(base_tick)
  );

  dct_divider #(.W(PRESCALE_W)) i_scale (
    .clk(clk), .rst_n(rst_n), .en(base_tick), .clr(chain_clr),
    .limit(prescale_limit(pre_sel)), .tick(cnt_tick)
  );

  assign zero      = wide ? (value_q == '0) : (value_q[HALF_W-1:0] == '0);
  assign underflow = cnt_tick && zero && !load_wr;
  assign value_rd  = wide ? value_q : {{(DATA_W-HALF_W){1'b0}}, value_q[HALF_W-1:0]};

  always_comb begin
    value_d = value_q;
    if (load_wr)       value_d = load_data;
    else if (cnt_tick) value_d = zero ? reload : value_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end
endmodule

// File: rtl/dct_free_counter.sv
module dct_free_counter #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              halt,
  input  logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] count_q
);
  logic step;
  logic [DATA_W-1:0] count_d;

  dct_divider #(.W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .en(enable && !halt), .clr(!enable),
    .limit(divisor), .tick(step)
  );

  always_comb begin
    count_d = count_q;
    if (step) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/dct_timer.sv
module dct_timer
  import dct_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int PREDIV_W   = 10,
  parameter int FREE_DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] CMASK = DATA_W'(CTRL_WMASK);

  logic rst_n_s;
  logic [DATA_W-1:0]   ctrl_q, ctrl_d, reload_q, reload_d;
  logic [PREDIV_W-1:0] prediv_q, prediv_d;
  logic                raw_q, raw_d;
  logic [DATA_W-1:0]   value_q, value_rd, free_q;
  logic                underflow, halt, masked;
  logic                wr, load_wr, reload_wr, ctrl_wr, clear_wr, prediv_wr;
  dct_idx_e            idx;
  logic                hit;

  dct_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign idx       = dct_idx_e'(bus_addr[3:0]);
  assign hit       = (bus_addr >> 4) == '0;
  assign wr        = bus_sel && bus_we && hit;
  assign load_wr   = wr && (idx == IDX_LOAD);
  assign reload_wr = wr && (idx == IDX_RELOAD);
  assign ctrl_wr   = wr && (idx == IDX_CTRL);
  assign clear_wr  = wr && (idx == IDX_CLEAR);
  assign prediv_wr = wr && (idx == IDX_PREDIV);

  assign halt   = ctrl_q[CB_HALT_EN] && dbg_halt_i;
  assign masked = raw_q && ctrl_q[CB_IE];
  assign irq_o  = masked;

  always_comb begin
    ctrl_d   = ctrl_wr ? (bus_wdata & CMASK) : ctrl_q;
    reload_d = (load_wr || reload_wr) ? bus_wdata : reload_q;
    prediv_d = prediv_wr ? bus_wdata[PREDIV_W-1:0] : prediv_q;
    raw_d    = raw_q;
    if (underflow)     raw_d = 1'b1;
    else if (clear_wr) raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      prediv_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      prediv_q <= prediv_d;
      raw_q    <= raw_d;
    end
  end

  dct_down_counter #(.DATA_W(DATA_W), .PREDIV_W(PREDIV_W)) i_down (
    .clk(clk), .rst_n(rst_n_s), .run(ctrl_q[CB_RUN]), .halt(halt),
    .wide(ctrl_q[CB_WIDE]), .pre_sel(ctrl_q[CB_PRE_LO+1:CB_PRE_LO]),
    .prediv(prediv_q), .load_wr(load_wr), .load_data(bus_wdata),
    .reload(reload_q), .value_q(value_q), .value_rd(value_rd),
    .underflow(underflow)
  );

  dct_free_counter #(.DATA_W(DATA_W), .DIV_W(FREE_DIV_W)) i_free (
    .clk(clk), .rst_n(rst_n_s), .enable(ctrl_q[CB_FREE_EN]), .halt(halt),
    .divisor(ctrl_q[CB_FDIV_LO+FREE_DIV_W-1:CB_FDIV_LO]), .count_q(free_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (idx)
        IDX_LOAD, IDX_RELOAD: bus_rdata = reload_q;
        IDX_VALUE:            bus_rdata = value_rd;
        IDX_CTRL:             bus_rdata = ctrl_q;
        IDX_RAW:              bus_rdata = DATA_W'(raw_q);
        IDX_MASKED:           bus_rdata = DATA_W'(masked);
        IDX_PREDIV:           bus_rdata = DATA_W'(prediv_q);
        IDX_FREE:             bus_rdata = free_q;
        default:              bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] value_q,
  input logic [DATA_W-1:0] reload_q,
  input logic [DATA_W-1:0] free_q,
  input logic              raw_q,
  input logic              irq_o,
  input logic              dbg_halt_i,
  input logic              load_wr,
  input logic              clear_wr,
  input logic              underflow
);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl_q[5] |-> !irq_o);

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clear_wr && !underflow) |=> !raw_q);

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    underflow |=> raw_q);

  a_r4_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (underflow && !load_wr) |=> (value_q == $past(reload_q)));

  a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctrl_q[7] && !load_wr) |=> $stable(value_q));

  a_r10_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl_q[8] && dbg_halt_i && !load_wr) |=> ($stable(value_q) && $stable(free_q)));

  a_r9_free_single_step: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ($stable(free_q) || (free_q == $past(free_q) + 1'b1)));
endmodule

bind dct_timer dct_checker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n_s(rst_n_s), .ctrl_q(ctrl_q), .value_q(value_q),
  .reload_q(reload_q), .free_q(free_q), .raw_q(raw_q), .irq_o(irq_o),
  .dbg_halt_i(dbg_halt_i), .load_wr(load_wr), .clear_wr(clear_wr),
  .underflow(underflow)
);

// File: tb/test_dct_timer.sv
`timescale 1ns/10ps
module test_dct_timer;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          dbg_halt_i, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dct_timer i_dct_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt_i(dbg_halt_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(idx); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] data);
    bus_addr = AW'(idx);
    #0.1;
    data = bus_rdata;
  endtask

  task automatic rchk(input string req, input int idx, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(idx, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 9; i++) rchk("R1 reset reg", i, '0);
    chk("R1 irq at reset", DW'(irq_o), '0);
  endtask

  task automatic t_basic();
    wr(0, 3);
    rchk("R3 load sets value", 1, 3);
    rchk("R3 load readback", 0, 3);
    wr(2, 32'hA2);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k < 4) begin
        rchk("R4 decrement", 1, DW'(3 - k));
        rchk("R4 no early event", 4, 0);
      end else begin
        rchk("R4 reload on zero", 1, 3);
        rchk("R4 raw set", 4, 1);
        rchk("R8 masked set", 5, 1);
        chk("R8 irq high", DW'(irq_o), 1);
      end
    end
    wr(2, 0);
    wr(3, 32'h1234);
    rchk("R7 clear", 4, 0);
    chk("R7 irq low after clear", DW'(irq_o), 0);
  endtask

  task automatic t_reload_hold();
    logic [DW-1:0] v0;
    rd(1, v0);
    wr(6, 5);
    rchk("R3 reload readback", 6, 5);
    rchk("R3 reload via load idx", 0, 5);
    repeat (4) @(negedge clk);
    rchk("R11 value held while off", 1, v0);
    wr(1, 32'hDEAD);
    rchk("R2 value write ignored", 1, v0);
    rchk("R2 clear idx reads zero", 3, 0);
    rchk("R2 unused idx reads zero", 9, 0);
    wr(2, 32'hFFFF_FFFF);
    rchk("R2 control reserved bits", 2, 32'h00FF_03AE);
    wr(2, 0);
  endtask

  task automatic t_prescale();
    wr(0, 3);
    wr(2, 32'h82 | (1 << 2));
    repeat (15) @(negedge clk);
    rchk("R5 div16 not yet", 1, 3);
    @(negedge clk);
    rchk("R5 div16 tick", 1, 2);
    wr(2, 0);
    wr(7, 2);
    rchk("R2 predivider readback", 7, 2);
    wr(0, 3);
    wr(2, 32'h82);
    repeat (2) @(negedge clk);
    rchk("R5 prediv not yet", 1, 3);
    @(negedge clk);
    rchk("R5 prediv tick", 1, 2);
    wr(2, 0);
    wr(7, 0);
    wr(0, 3);
    wr(2, 32'h82 | (2 << 2));
    repeat (255) @(negedge clk);
    rchk("R5 div256 not yet", 1, 3);
    @(negedge clk);
    rchk("R5 div256 tick", 1, 2);
    wr(2, 0);
    wr(0, 3);
    wr(2, 32'h82 | (3 << 2));
    @(negedge clk);
    rchk("R5 sel3 divides by 1", 1, 2);
    wr(2, 0);
    wr(3, 0);
  endtask

  task automatic t_width();
    wr(0, 32'h0001_0002);
    rchk("R6 16-bit readout", 1, 32'h0000_0002);
    wr(2, 32'h80);
    @(negedge clk); rchk("R6 16-bit count", 1, 1);
    @(negedge clk); rchk("R6 16-bit zero", 1, 0);
    @(negedge clk);
    rchk("R6 16-bit reload", 1, 2);
    rchk("R6 raw set", 4, 1);
    rchk("R8 masked off without enable", 5, 0);
    chk("R8 irq off without enable", DW'(irq_o), 0);
    wr(2, 0); wr(3, 0);
    wr(0, 32'h0001_0000);
    wr(2, 32'h82);
    @(negedge clk);
    rchk("R6 32-bit borrow", 1, 32'h0000_FFFF);
    rchk("R6 32-bit no event", 4, 0);
    wr(2, 0); wr(3, 0);
    wr(0, 32'h0001_0000);
    wr(2, 32'h80);
    @(negedge clk);
    rchk("R6 16-bit low half zero event", 4, 1);
    wr(2, 0); wr(3, 0);
  endtask

  task automatic t_collide();
    wr(0, 0);
    wr(2, 32'hA2);
    repeat (2) @(negedge clk);
    rchk("R4 zero reload events", 4, 1);
    wr(3, 0);
    rchk("R7 event wins over clear", 4, 1);
    wr(2, 0);
    wr(3, 0);
    rchk("R7 clear after stop", 4, 0);
  endtask

  task automatic t_load_priority();
    wr(0, 10);
    wr(2, 32'h82);
    wr(0, 100);
    rchk("R3 load beats tick", 1, 100);
    @(negedge clk);
    rchk("R3 count resumes", 1, 99);
    wr(2, 0);
  endtask

  task automatic t_free();
    wr(2, 32'h0003_0200);
    repeat (3) @(negedge clk); rchk("R9 free before step", 8, 0);
    @(negedge clk);            rchk("R9 free first step", 8, 1);
    repeat (4) @(negedge clk); rchk("R9 free second step", 8, 2);
    wr(2, 0);
    repeat (5) @(negedge clk); rchk("R9 free holds when off", 8, 2);
    wr(8, 32'h55);
    rchk("R2 free write ignored", 8, 2);
  endtask

  task automatic t_halt();
    logic [DW-1:0] v0, c0;
    wr(0, 50);
    wr(2, 32'h0000_0382);
    @(negedge clk);
    rd(1, v0); rd(8, c0);
    dbg_halt_i = 1'b1;
    repeat (5) @(negedge clk);
    rchk("R10 value frozen", 1, v0);
    rchk("R10 free frozen", 8, c0);
    dbg_halt_i = 1'b0;
    @(negedge clk);
    rchk("R10 value resumes", 1, v0 - 1);
    rchk("R10 free resumes", 8, c0 + 1);
    wr(2, 32'h0000_0282);
    rd(1, v0); rd(8, c0);
    dbg_halt_i = 1'b1;
    repeat (3) @(negedge clk);
    rchk("R10 halt ignored value", 1, v0 - 3);
    rchk("R10 halt ignored free", 8, c0 + 3);
    dbg_halt_i = 1'b0;
    wr(2, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; dbg_halt_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_reload_hold();
    t_prescale();
    t_width();
    t_collide();
    t_load_priority();
    t_free();
    t_halt();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule